// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block collects interrupt events from several hardware sources into one status word for a small processor system. Each source, such as a serial receiver reporting a finished byte or a debounced push-button, drives a one-cycle pulse. The pulse sets the bit assigned to that source, and the bit stays set until software clears it. A single interrupt request line tells the processor that at least one bit is pending.

Software reads the whole word to find out which sources fired. It acknowledges them by writing a mask in which each 1 clears the matching bit. A write can never set a bit, so only hardware raises status. When a source pulses in the same cycle as a clear of its bit, the bit stays set and the event is not lost. The status word is 8 bits wide, and the positions above the configured number of sources always read as zero.

Top module: `irq_status_reg`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and right after it is released, `rd_data` is 0 and `irq` is 0.
- R2: A 1 on `src_pulse[i]` at a rising edge makes `rd_data[i]` read 1 after that edge.
- R3: With `wr_en` high at a rising edge, every `wr_data` bit that is 1 clears the status bit at the same position. Status bits whose `wr_data` bit is 0 keep their value.
- R4: A write never sets a status bit, including when it carries 1s at positions 7 down to NUM_SRC, which have no source.
- R5: When a source pulse and a write that clears the same bit arrive at the same edge, the bit reads 1 after that edge.
- R6: `rd_data` bits 7 down to NUM_SRC always read 0.
- R7: `irq` is registered from the status word. After each rising edge it equals the OR of the status bits as they stood before that edge, so it rises and falls one cycle after the status word changes between zero and non-zero.
- R8: With no source pulse and `wr_en` low, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_en | input | 1 | Processor write strobe for the clear mask |
| wr_data | input | 8 | Clear mask: 1 clears the bit, 0 leaves it unchanged |
| rd_data | output | 8 | Current status word, upper unused bits zero |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
A source pulse or a clear mask applied before an edge shows on `rd_data` right after that edge. `irq` follows one edge later, because it is registered from the status word. The bench drives inputs on the falling edge and reads the status word at the next falling edge. It reads `irq` at the falling edge after that, so each check samples the cycle in which its result becomes valid. The sweep covers every pending state, every clear mask over the source bits and every pulse pattern, applied together at one edge.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 4,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr_mask;

  assign clr_mask = wr_en ? wr_data[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | src_pulse;
      irq    <= |pend_q;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, pend_q};
    end else begin : g_nopad
      assign rd_data = pend_q;
    end
  endgenerate
endmodule

module irq_status_reg_chk #(
  parameter int NUM_SRC = 4,
  parameter int REG_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_pulse,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic               irq
);
  logic [REG_W-1:0] src_ext;
  logic [REG_W-1:0] clr_ext;
  assign src_ext = REG_W'(src_pulse);
  assign clr_ext = wr_en ? wr_data : '0;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (rd_data == '0 && !irq));

  // R2
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((rd_data & $past(src_ext)) == $past(src_ext)));

  // R4
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ~$past(rd_data) & ~$past(src_ext)) == '0));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & $past(clr_ext) & ~$past(src_ext)) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(rd_data) != '0)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && src_pulse == '0) |=> $stable(rd_data));
endmodule

bind irq_status_reg irq_status_reg_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_irq_status_reg.sv
`timescale 1ns/1ps
module sim_irq_status_reg;
  localparam int NS = 4;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_pulse = '0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_reg #(.NUM_SRC(NS), .REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [W-1:0] wd, logic [NS-1:0] sp);
    wr_en = we; wr_data = wd; src_pulse = sp;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; src_pulse = '0;
  endtask

  initial begin
    #1;
    chk("R1 reset rd", rd_data, '0);
    chk("R1 reset irq", {7'd0, irq}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release rd", rd_data, '0);
    chk("R1 after release irq", {7'd0, irq}, '0);

    for (int s = 0; s < (1 << NS); s++) begin
      for (int m = 0; m < (1 << NS); m++) begin
        for (int p = 0; p < (1 << NS); p++) begin
          logic [W-1:0] e;
          logic [W-1:0] wmask;
          step(1'b1, 8'hFF, '0);
          step(1'b0, '0, NS'(s));
          chk("R2 set", rd_data, W'(s));
          wmask = {4'((s + m + p) | 1), 4'(m)};
          e = W'((s & ~m) | p);
          step(1'b1, wmask, NS'(p));
          // R3 R4 R5 R6: clear mask, upper ones never set, set wins
          chk("R3/R4/R5/R6 clear+set", rd_data, e);
          chk("R7 irq lag", {7'd0, irq}, {7'd0, s != 0});
          @(negedge clk);
          chk("R7 irq follows", {7'd0, irq}, {7'd0, e != '0});
          chk("R8 hold", rd_data, e);
        end
      end
    end

    step(1'b0, '0, 4'b1010);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset rd", rd_data, '0);
    chk("R1 mid-run reset irq", {7'd0, irq}, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule